// File: doc/BRIEF.md
# Message-Buffer Interrupt Flag Controller

This block holds a pending flag and an enable mask for each of 64 message buffers. A message engine reports each finished transmit or receive with a one-cycle strobe on that buffer's line, and the buffer's flag is set. Software reads the flags over a small word-addressed register bus and clears them by writing ones. A single interrupt request goes high whenever any buffer has both its flag and its mask set.

The block also decides whether a CPU write to a buffer's storage may go ahead. When abort mode is on, a buffer that is set up for transmit and still has its flag pending refuses CPU writes until software clears the flag. Receive buffers are always writable. When abort mode is off, every buffer is writable.

The flags and masks are split into 32-buffer groups. Within a register word the bit order is reversed relative to buffer number.

Top module: `mbuf_irq_ctrl`

## Requirements
- R1: Register map (word addresses): 0 = flags of buffers 0..31, 1 = flags of buffers 32..63, 2 = masks of buffers 0..31, 3 = masks of buffers 32..63. In the word for group g, bit k holds buffer 32*g + 31 - k. Bit 31 of address 0 is buffer 0, and bit 0 of address 1 is buffer 63.
- R2: A high `done_i[n]` at a clock edge sets flag n. The new value is visible on a read after that edge.
- R3: Writing a flag word clears each flag whose bit is 1 and leaves each flag whose bit is 0 unchanged. A flag is never set except by `done_i`.
- R4: If `done_i[n]` and a clearing write to flag n fall on the same edge, flag n ends up set.
- R5: `irq_o` is high exactly when some buffer has both its flag and its mask set. It follows a mask or flag change in the same cycle as the register update, with no further delay.
- R6: After reset, all flags and all masks are 0 and `irq_o` is low.
- R7: Mask words can be written and read back. A mask write leaves the flags unchanged.
- R8: `mbw_grant` is low when `mbw_req` is low. While `mbw_req` is high, it is low only when `abort_en` = 1, `dir_tx[mbw_idx]` = 1 (1 means transmit), and that buffer's flag is set.
- R9: Addresses 4..7 read as zero, and writes to them change no flag or mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| done_i | input | 64 | Per-buffer completion strobe |
| dir_tx | input | 64 | Per-buffer direction, 1 = transmit |
| abort_en | input | 1 | Abort mode enable |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register word address |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data for `bus_addr` |
| mbw_req | input | 1 | CPU requests a write to buffer storage |
| mbw_idx | input | 6 | Buffer targeted by the write request |
| mbw_grant | output | 1 | Write to buffer storage allowed |
| irq_o | output | 1 | Combined interrupt request |

## Verification
The assertions assume that `done_i` is driven only after reset is released. They also assume that `mbw_idx` always names an existing buffer. The stimulus changes inputs only a small delay after a rising edge and raises strobes only after reset, so both assumptions hold. The property that checks set-over-clear priority also relies on a write to flags and a strobe being able to meet on one edge. The bench forces that collision on purpose.

// File: rtl/mbuf_irq_pkg.sv
package mbuf_irq_pkg;
    typedef enum logic [1:0] {
        BANK_NONE = 2'd0,
        BANK_FLAG = 2'd1,
        BANK_MASK = 2'd2
    } bank_e;
endpackage

// File: rtl/mbuf_bus_decode.sv
module mbuf_bus_decode
    import mbuf_irq_pkg::*;
#(
    parameter int NUM_BUF = 64,
    parameter int WORD_W  = 32,
    parameter int ADDR_W  = 3
) (
    input  logic                bus_wr,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [WORD_W-1:0]   bus_wdata,
    input  logic [NUM_BUF-1:0]  flag_q,
    input  logic [NUM_BUF-1:0]  mask_q,
    output logic [NUM_BUF-1:0]  clr_o,
    output logic [NUM_BUF-1:0]  mask_we_o,
    output logic [NUM_BUF-1:0]  mask_val_o,
    output logic [WORD_W-1:0]   rdata_o
);
    localparam int NUM_GRP = NUM_BUF / WORD_W;
    localparam int GRP_W   = (NUM_GRP > 1) ? $clog2(NUM_GRP) : 1;

    bank_e             bank;
    logic [GRP_W-1:0]  grp;
    logic [31:0]       addr_ext;
    logic [WORD_W-1:0] flag_word [NUM_GRP];
    logic [WORD_W-1:0] mask_word [NUM_GRP];

    always_comb begin
        addr_ext = 32'(bus_addr);
        bank     = BANK_NONE;
        grp      = '0;
        if (addr_ext < 32'(NUM_GRP)) begin
            bank = BANK_FLAG;
            grp  = GRP_W'(addr_ext);
        end else if (addr_ext < 32'(2 * NUM_GRP)) begin
            bank = BANK_MASK;
            grp  = GRP_W'(addr_ext - 32'(NUM_GRP));
        end
    end

    for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
        for (genvar k = 0; k < WORD_W; k++) begin : g_bit
            localparam int BUF = g * WORD_W + (WORD_W - 1 - k);
            assign clr_o[BUF]      = bus_wr && (bank == BANK_FLAG) && (grp == GRP_W'(g)) && bus_wdata[k];
            assign mask_we_o[BUF]  = bus_wr && (bank == BANK_MASK) && (grp == GRP_W'(g));
            assign mask_val_o[BUF] = bus_wdata[k];
            assign flag_word[g][k] = flag_q[BUF];
            assign mask_word[g][k] = mask_q[BUF];
        end
    end

    always_comb begin
        case (bank)
            BANK_FLAG: rdata_o = flag_word[grp];
            BANK_MASK: rdata_o = mask_word[grp];
            default:   rdata_o = '0;
        endcase
    end
endmodule

// File: rtl/mbuf_irq_reduce.sv
module mbuf_irq_reduce #(
    parameter int NUM_BUF = 64,
    parameter int WORD_W  = 32
) (
    input  logic [NUM_BUF-1:0] flag_q,
    input  logic [NUM_BUF-1:0] mask_q,
    output logic               irq_o
);
    localparam int NUM_GRP = NUM_BUF / WORD_W;

    logic [NUM_GRP-1:0] grp_req;

    for (genvar g = 0; g < NUM_GRP; g++) begin : g_req
        assign grp_req[g] = |(flag_q[g*WORD_W +: WORD_W] & mask_q[g*WORD_W +: WORD_W]);
    end

    assign irq_o = |grp_req;
endmodule

// File: rtl/mbuf_write_gate.sv
module mbuf_write_gate #(
    parameter int NUM_BUF = 64,
    parameter int IDX_W   = 6
) (
    input  logic               req_i,
    input  logic [IDX_W-1:0]   idx_i,
    input  logic               abort_en,
    input  logic [NUM_BUF-1:0] dir_tx,
    input  logic [NUM_BUF-1:0] flag_q,
    output logic               grant_o
);
    logic veto;

    always_comb begin
        veto    = abort_en && dir_tx[idx_i] && flag_q[idx_i];
        grant_o = req_i && !veto;
    end
endmodule

// File: rtl/mbuf_irq_ctrl.sv
module mbuf_irq_ctrl #(
    parameter int NUM_BUF = 64,
    parameter int WORD_W  = 32,
    parameter int ADDR_W  = 3,
    localparam int IDX_W  = $clog2(NUM_BUF)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_BUF-1:0] done_i,
    input  logic [NUM_BUF-1:0] dir_tx,
    input  logic               abort_en,
    input  logic               bus_wr,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [WORD_W-1:0]  bus_wdata,
    output logic [WORD_W-1:0]  bus_rdata,
    input  logic               mbw_req,
    input  logic [IDX_W-1:0]   mbw_idx,
    output logic               mbw_grant,
    output logic               irq_o
);
    typedef struct packed {
        logic [NUM_BUF-1:0] flag;
        logic [NUM_BUF-1:0] mask;
    } state_t;

    state_t state_d, state_q;

    logic [NUM_BUF-1:0] flag_q, mask_q;
    logic [NUM_BUF-1:0] clr, mask_we, mask_val;

    assign flag_q = state_q.flag;
    assign mask_q = state_q.mask;

    mbuf_bus_decode #(.NUM_BUF(NUM_BUF), .WORD_W(WORD_W), .ADDR_W(ADDR_W)) u_dec (
        .bus_wr     (bus_wr),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .flag_q     (flag_q),
        .mask_q     (mask_q),
        .clr_o      (clr),
        .mask_we_o  (mask_we),
        .mask_val_o (mask_val),
        .rdata_o    (bus_rdata)
    );

    mbuf_irq_reduce #(.NUM_BUF(NUM_BUF), .WORD_W(WORD_W)) u_req (
        .flag_q (flag_q),
        .mask_q (mask_q),
        .irq_o  (irq_o)
    );

    mbuf_write_gate #(.NUM_BUF(NUM_BUF), .IDX_W(IDX_W)) u_gate (
        .req_i    (mbw_req),
        .idx_i    (mbw_idx),
        .abort_en (abort_en),
        .dir_tx   (dir_tx),
        .flag_q   (flag_q),
        .grant_o  (mbw_grant)
    );

    always_comb begin
        state_d      = state_q;
        // a strobe on the same edge as a clear keeps the flag set
        state_d.flag = (state_q.flag & ~clr) | done_i;
        state_d.mask = (state_q.mask & ~mask_we) | (mask_val & mask_we);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end
endmodule

// File: rtl/mbuf_irq_chk.sv
module mbuf_irq_chk #(
    parameter int NUM_BUF = 64,
    parameter int IDX_W   = 6
) (
    input logic               clk,
    input logic               rst_n,
    input logic [NUM_BUF-1:0] done_i,
    input logic [NUM_BUF-1:0] flag_q,
    input logic [NUM_BUF-1:0] mask_q,
    input logic               irq_o,
    input logic               mbw_req,
    input logic [IDX_W-1:0]   mbw_idx,
    input logic               abort_en,
    input logic [NUM_BUF-1:0] dir_tx,
    input logic               mbw_grant
);
    AST_STROBE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (|done_i) |=> ((flag_q & $past(done_i)) == $past(done_i))); // R2

    AST_NO_SPURIOUS_SET: assert property (@(posedge clk) disable iff (!rst_n)
        ((flag_q & ~$past(flag_q) & ~$past(done_i)) == '0)); // R3

    AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_q == '0) |-> !irq_o); // R5

    AST_MASK_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> ((mask_q == '0) && !irq_o)); // R6

    AST_GRANT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !mbw_req |-> !mbw_grant); // R8

    AST_GRANT_NO_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
        (mbw_req && !abort_en) |-> mbw_grant); // R8

    AST_GRANT_RX: assert property (@(posedge clk) disable iff (!rst_n)
        (mbw_req && !dir_tx[mbw_idx]) |-> mbw_grant); // R8
endmodule

bind mbuf_irq_ctrl mbuf_irq_chk #(.NUM_BUF(NUM_BUF), .IDX_W(IDX_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .done_i    (done_i),
    .flag_q    (flag_q),
    .mask_q    (mask_q),
    .irq_o     (irq_o),
    .mbw_req   (mbw_req),
    .mbw_idx   (mbw_idx),
    .abort_en  (abort_en),
    .dir_tx    (dir_tx),
    .mbw_grant (mbw_grant)
);

// File: tb/test_mbuf_irq_ctrl.sv
`timescale 1ns/1ps
module test_mbuf_irq_ctrl;
    localparam int NB = 64;
    localparam int WW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NB-1:0] done_i = '0;
    logic [NB-1:0] dir_tx = '0;
    logic          abort_en = 1'b0;
    logic          bus_wr = 1'b0;
    logic [2:0]    bus_addr = '0;
    logic [WW-1:0] bus_wdata = '0;
    logic [WW-1:0] bus_rdata;
    logic          mbw_req = 1'b0;
    logic [5:0]    mbw_idx = '0;
    logic          mbw_grant;
    logic          irq_o;

    always #2.5 clk = ~clk;

    mbuf_irq_ctrl i_mbuf_irq_ctrl (
        .clk(clk), .rst_n(rst_n), .done_i(done_i), .dir_tx(dir_tx),
        .abort_en(abort_en), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .mbw_req(mbw_req),
        .mbw_idx(mbw_idx), .mbw_grant(mbw_grant), .irq_o(irq_o)
    );

    typedef struct {
        int          kind;   // 0 rdata, 1 irq, 2 grant
        logic [31:0] exp;
        string       tag;
    } item_t;

    item_t sb[$];
    int n_tests = 0;
    int n_fail  = 0;
    logic finished = 1'b0;

    logic [NB-1:0] m_flag = '0;
    logic [NB-1:0] m_mask = '0;

    function automatic logic [31:0] word_of(int g, logic [NB-1:0] v);
        logic [31:0] w;
        for (int k = 0; k < WW; k++) w[k] = v[g*WW + WW-1-k];
        return w;
    endfunction

    always @(negedge clk) begin
        while (sb.size() > 0) begin
            item_t it;
            logic [31:0] act;
            it = sb.pop_front();
            case (it.kind)
                0:       act = bus_rdata;
                1:       act = {31'b0, irq_o};
                default: act = {31'b0, mbw_grant};
            endcase
            n_tests++;
            if (act !== it.exp) begin
                n_fail++;
                $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
            end
        end
    end

    task automatic observe(int kind, logic [31:0] exp, string tag);
        item_t it;
        it.kind = kind; it.exp = exp; it.tag = tag;
        sb.push_back(it);
        @(negedge clk);
        #1;
    endtask

    task automatic rd_chk(logic [2:0] a, logic [31:0] exp, string tag);
        bus_addr = a;
        observe(0, exp, tag);
    endtask

    task automatic wr(logic [2:0] a, logic [31:0] d);
        @(posedge clk); #1;
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic strobe(logic [NB-1:0] v);
        @(posedge clk); #1;
        done_i = v;
        @(posedge clk); #1;
        done_i = '0;
        m_flag = m_flag | v;
    endtask

    task automatic check_all(string tag);
        rd_chk(3'd0, word_of(0, m_flag), tag);
        rd_chk(3'd1, word_of(1, m_flag), tag);
        rd_chk(3'd2, word_of(0, m_mask), tag);
        rd_chk(3'd3, word_of(1, m_mask), tag);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R6 reset state
        check_all("R6 reset registers");
        observe(1, 32'd0, "R6 irq after reset");

        // R2 / R1: set buffers 0, 5, 40, 63
        strobe((64'd1 << 0) | (64'd1 << 5) | (64'd1 << 40) | (64'd1 << 63));
        rd_chk(3'd0, 32'h8400_0000, "R2 R1 low flag word");
        rd_chk(3'd1, 32'h0080_0001, "R2 R1 high flag word");
        observe(1, 32'd0, "R5 irq low while masks clear");

        // R7 / R5: enable buffer 0
        wr(3'd2, 32'h8000_0000);
        m_mask[0] = 1'b1;
        observe(1, 32'd1, "R5 irq after mask set");
        check_all("R7 mask write keeps flags");
        wr(3'd2, 32'h0000_0000);
        m_mask[0] = 1'b0;
        observe(1, 32'd0, "R5 irq drops with mask clear");

        // R3: clear buffer 5, also write 1 to an idle flag (buffer 31)
        wr(3'd0, 32'h0400_0001);
        m_flag[5] = 1'b0;
        rd_chk(3'd0, word_of(0, m_flag), "R3 write one clears");
        wr(3'd0, 32'h0000_0000);
        wr(3'd1, 32'h0000_0000);
        check_all("R3 write zero no effect");

        // R4: set and clear buffer 0 on the same edge
        @(posedge clk); #1;
        done_i = 64'd1;
        bus_wr = 1'b1; bus_addr = 3'd0; bus_wdata = 32'h8000_0000;
        @(posedge clk); #1;
        done_i = '0; bus_wr = 1'b0; bus_wdata = '0;
        rd_chk(3'd0, 32'h8000_0000, "R4 set wins over clear");

        // R5 with high group: buffer 63 is bit 0 of address 3
        wr(3'd3, 32'h0000_0001);
        m_mask[63] = 1'b1;
        observe(1, 32'd1, "R5 R1 irq from buffer 63");
        wr(3'd1, 32'h0000_0001);
        m_flag[63] = 1'b0;
        observe(1, 32'd0, "R5 irq low after flag clear");

        // R8 write gating
        dir_tx = 64'd1 << 40 | 64'd1 << 41;
        abort_en = 1'b1;
        mbw_req = 1'b0; mbw_idx = 6'd40;
        observe(2, 32'd0, "R8 no request no grant");
        mbw_req = 1'b1;
        observe(2, 32'd0, "R8 pending tx blocked");
        abort_en = 1'b0;
        observe(2, 32'd1, "R8 abort off granted");
        abort_en = 1'b1; mbw_idx = 6'd41;
        observe(2, 32'd1, "R8 tx without flag granted");
        mbw_idx = 6'd0;
        observe(2, 32'd1, "R8 rx with flag granted");
        wr(3'd1, 32'h0080_0000);
        m_flag[40] = 1'b0;
        mbw_idx = 6'd40;
        observe(2, 32'd1, "R8 granted after flag clear");
        mbw_req = 1'b0; abort_en = 1'b0;

        // R9 unmapped space
        wr(3'd5, 32'hFFFF_FFFF);
        wr(3'd7, 32'hFFFF_FFFF);
        rd_chk(3'd5, 32'd0, "R9 unmapped reads zero");
        rd_chk(3'd6, 32'd0, "R9 unmapped reads zero");
        check_all("R9 unmapped write ignored");

        if (!finished) begin
            finished = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule